// File: doc/BRIEF.md
# Syllable Stream Instruction Decoder

The decoder accepts 8-bit code syllables one per handshake on a valid/ready input. It groups them into complete instructions and, for each one, presents a single record on a valid/ready output. The record holds the operator class, the leading opcode syllable, the total syllable count and an immediate field built from the syllables that follow the first one.

The two most significant bits of the first syllable decide the form of the instruction. A value of 00 marks a value call and 01 marks a name call. Both take one more syllable, and the six low bits of the first syllable are joined with that syllable to give a 14-bit address couple. Any other first syllable is an opcode. The opcode sets how many trailing syllables follow: none for plain operators, one or two for short literals, two for static branches and four for the long literal. Opcode FF is flagged as invalid.

A completed record stays on the output until the consumer accepts it, and no new syllable is taken while a record is pending. Reset throws away any instruction that is only partly collected.

Top module: `syl_decoder`

## Requirements
- R1: After reset, ins_valid_o is 0 and syl_ready_o is 1.
- R2: A first syllable s0 with s0[7:6]=00 gives class 0 (value call) and length 2. The immediate is {s0[5:0], s1}, zero-extended to 32 bits, where s1 is the next syllable.
- R3: A first syllable with s0[7:6]=01 gives class 1 (name call). Length and immediate are formed as in R2.
- R4: A first syllable with s0[7]=1 that is not listed in R5, R6 or R7 gives class 2, length 1 and immediate 0.
- R5: Opcodes A0 (branch if false), A1 (branch if true) and A2 (branch always) give class 3 and length 3. The immediate is the 16-bit offset from the next two syllables, most significant byte first.
- R6: Opcodes B2 (8-bit literal), B3 (16-bit literal) and BE (long literal) give class 4. Their lengths are 2, 3 and 5. The immediate is the trailing syllables packed most significant byte first.
- R7: Opcode FF gives class 5, length 1 and ins_bad_o=1. Every other record has ins_bad_o=0.
- R8: While ins_valid_o=1 and ins_ready_i=0, the record stays stable and syl_ready_o=0. A syllable offered during that time is only taken after the record has been accepted.
- R9: Asserting reset partway through an instruction discards the collected syllables. Decoding then restarts at the next syllable.
- R10: Idle cycles on syl_valid_i between the syllables of one instruction do not change the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| syl_valid_i | input | 1 | Input syllable valid |
| syl_data_i | input | 8 | Input syllable |
| syl_ready_o | output | 1 | Decoder can take a syllable |
| ins_valid_o | output | 1 | Instruction record valid |
| ins_ready_i | input | 1 | Consumer accepts the record |
| ins_class_o | output | 3 | Operator class (0 to 5) |
| ins_op_o | output | 8 | First syllable of the instruction |
| ins_len_o | output | 3 | Total syllable count |
| ins_imm_o | output | 32 | Immediate from the trailing syllables |
| ins_bad_o | output | 1 | Invalid opcode flag |

## Verification
The bench sends every one of the 256 possible first syllables. Each is followed by trailing bytes derived from its value and by an idle gap between syllables that varies from one instruction to the next. This tells the two call forms, the branch, literal, plain and invalid classes apart by length and by how the immediate is packed. A stalled consumer with a syllable already offered shows whether the record holds and whether that syllable is kept for the next instruction. A reset in the middle of a branch shows that the partial state is dropped.

// File: rtl/syl_dec_pkg.sv
package syl_dec_pkg;
  localparam int SYL_W = 8;

  typedef enum logic [2:0] {
    CLS_VAL    = 3'd0,
    CLS_NAME   = 3'd1,
    CLS_OPER   = 3'd2,
    CLS_BRANCH = 3'd3,
    CLS_LIT    = 3'd4,
    CLS_BAD    = 3'd5
  } ins_class_e;

  localparam logic [SYL_W-1:0] OP_BR_FALSE = 8'hA0;
  localparam logic [SYL_W-1:0] OP_BR_TRUE  = 8'hA1;
  localparam logic [SYL_W-1:0] OP_BR_ALWAYS = 8'hA2;
  localparam logic [SYL_W-1:0] OP_LIT_8    = 8'hB2;
  localparam logic [SYL_W-1:0] OP_LIT_16   = 8'hB3;
  localparam logic [SYL_W-1:0] OP_LIT_LONG = 8'hBE;
  localparam logic [SYL_W-1:0] OP_INVALID  = 8'hFF;

  localparam int CALL_LOW_W = 6;
  localparam int LONG_TRAIL = 4;
endpackage

// File: rtl/syl_classify.sv
module syl_classify
  import syl_dec_pkg::*;
#(
  parameter int TRAIL_W = 3
) (
  input  logic [SYL_W-1:0]   syl_i,
  output ins_class_e         cls_o,
  output logic [TRAIL_W-1:0] trail_o,
  output logic               bad_o
);
  always_comb begin
    cls_o   = CLS_OPER;
    trail_o = '0;
    bad_o   = 1'b0;
    if (!syl_i[SYL_W-1]) begin
      cls_o   = syl_i[SYL_W-2] ? CLS_NAME : CLS_VAL;
      trail_o = TRAIL_W'(1);
    end else begin
      case (syl_i)
        OP_BR_FALSE, OP_BR_TRUE, OP_BR_ALWAYS: begin
          cls_o   = CLS_BRANCH;
          trail_o = TRAIL_W'(2);
        end
        OP_LIT_8: begin
          cls_o   = CLS_LIT;
          trail_o = TRAIL_W'(1);
        end
        OP_LIT_16: begin
          cls_o   = CLS_LIT;
          trail_o = TRAIL_W'(2);
        end
        OP_LIT_LONG: begin
          cls_o   = CLS_LIT;
          trail_o = TRAIL_W'(LONG_TRAIL);
        end
        OP_INVALID: begin
          cls_o = CLS_BAD;
          bad_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/syl_gather.sv
module syl_gather
  import syl_dec_pkg::*;
#(
  parameter int MAX_TRAIL = 4,
  localparam int IMM_W   = SYL_W * MAX_TRAIL,
  localparam int TRAIL_W = $clog2(MAX_TRAIL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [IMM_W-1:0]   load_imm_i,
  input  logic [TRAIL_W-1:0] load_cnt_i,
  input  logic               shift_i,
  input  logic [SYL_W-1:0]   syl_i,
  output logic [IMM_W-1:0]   imm_o,
  output logic [TRAIL_W-1:0] remain_o
);
  logic [SYL_W-1:0]   lane_q [MAX_TRAIL];
  logic [TRAIL_W-1:0] remain_q;

  // lane 0 is the least significant byte; new syllables enter there
  for (genvar i = 0; i < MAX_TRAIL; i++) begin : g_lane
    logic [SYL_W-1:0] shift_in;
    if (i == 0) begin : g_first
      assign shift_in = syl_i;
    end else begin : g_rest
      assign shift_in = lane_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q[i] <= '0;
      else if (load_i)  lane_q[i] <= load_imm_i[i*SYL_W +: SYL_W];
      else if (shift_i) lane_q[i] <= shift_in;
    end

    assign imm_o[i*SYL_W +: SYL_W] = lane_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      remain_q <= '0;
    else if (load_i)  remain_q <= load_cnt_i;
    else if (shift_i && remain_q != '0) remain_q <= remain_q - TRAIL_W'(1);
  end

  assign remain_o = remain_q;
endmodule

// File: rtl/syl_decoder.sv
module syl_decoder
  import syl_dec_pkg::*;
#(
  parameter int MAX_TRAIL = 4,
  localparam int IMM_W   = SYL_W * MAX_TRAIL,
  localparam int TRAIL_W = $clog2(MAX_TRAIL + 1),
  localparam int LEN_W   = $clog2(MAX_TRAIL + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             syl_valid_i,
  input  logic [SYL_W-1:0] syl_data_i,
  output logic             syl_ready_o,
  output logic             ins_valid_o,
  input  logic             ins_ready_i,
  output logic [2:0]       ins_class_o,
  output logic [SYL_W-1:0] ins_op_o,
  output logic [LEN_W-1:0] ins_len_o,
  output logic [IMM_W-1:0] ins_imm_o,
  output logic             ins_bad_o
);
  ins_class_e         cls_d;
  logic [TRAIL_W-1:0] trail_d;
  logic               bad_d;
  logic               accept, first, last_trail;
  logic               busy_q, out_q, bad_q;
  ins_class_e         cls_q;
  logic [SYL_W-1:0]   op_q;
  logic [LEN_W-1:0]   len_q;
  logic [IMM_W-1:0]   seed;
  logic [TRAIL_W-1:0] remain;

  assign syl_ready_o = !out_q;
  assign accept      = syl_valid_i && syl_ready_o;
  assign first       = accept && !busy_q;
  assign last_trail  = accept && busy_q && remain == TRAIL_W'(1);

  syl_classify #(.TRAIL_W(TRAIL_W)) u_classify (
    .syl_i   (syl_data_i),
    .cls_o   (cls_d),
    .trail_o (trail_d),
    .bad_o   (bad_d)
  );

  // call forms carry the low bits of the first syllable into the couple
  always_comb begin
    seed = '0;
    if (cls_d == CLS_VAL || cls_d == CLS_NAME)
      seed[CALL_LOW_W-1:0] = syl_data_i[CALL_LOW_W-1:0];
  end

  syl_gather #(.MAX_TRAIL(MAX_TRAIL)) u_gather (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (first),
    .load_imm_i (seed),
    .load_cnt_i (trail_d),
    .shift_i    (accept && busy_q),
    .syl_i      (syl_data_i),
    .imm_o      (ins_imm_o),
    .remain_o   (remain)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      out_q  <= 1'b0;
      bad_q  <= 1'b0;
      cls_q  <= CLS_OPER;
      op_q   <= '0;
      len_q  <= '0;
    end else begin
      if (out_q && ins_ready_i) out_q <= 1'b0;
      if (first) begin
        op_q  <= syl_data_i;
        cls_q <= cls_d;
        bad_q <= bad_d;
        len_q <= LEN_W'(trail_d) + LEN_W'(1);
        if (trail_d == '0) out_q  <= 1'b1;
        else               busy_q <= 1'b1;
      end
      if (last_trail) begin
        busy_q <= 1'b0;
        out_q  <= 1'b1;
      end
    end
  end

  assign ins_valid_o = out_q;
  assign ins_class_o = cls_q;
  assign ins_op_o    = op_q;
  assign ins_len_o   = len_q;
  assign ins_bad_o   = bad_q;
endmodule

// File: rtl/syl_decoder_chk.sv
module syl_decoder_chk
  import syl_dec_pkg::*;
#(
  parameter int MAX_TRAIL = 4,
  localparam int IMM_W = SYL_W * MAX_TRAIL,
  localparam int LEN_W = $clog2(MAX_TRAIL + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             syl_valid_i,
  input logic             syl_ready_o,
  input logic             ins_valid_o,
  input logic             ins_ready_i,
  input logic [2:0]       ins_class_o,
  input logic [SYL_W-1:0] ins_op_o,
  input logic [LEN_W-1:0] ins_len_o,
  input logic [IMM_W-1:0] ins_imm_o,
  input logic             ins_bad_o
);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_ready_i |=> ins_valid_o && $stable(ins_op_o)
      && $stable(ins_imm_o) && $stable(ins_class_o) && $stable(ins_len_o));

  p_no_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> !syl_ready_o);

  p_bad_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> (ins_bad_o == (ins_op_o == OP_INVALID))
      && (ins_bad_o == (ins_class_o == 3'(CLS_BAD))));

  p_call_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && !ins_op_o[SYL_W-1] |-> ins_len_o == LEN_W'(2)
      && ins_imm_o[IMM_W-1:14] == '0 && ins_class_o == {2'b00, ins_op_o[SYL_W-2]});

  p_plain_op_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o && ins_class_o == 3'(CLS_OPER) |-> ins_len_o == LEN_W'(1) && ins_imm_o == '0);

  p_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ins_valid_o) |-> $past(syl_valid_i));
endmodule

bind syl_decoder syl_decoder_chk #(.MAX_TRAIL(MAX_TRAIL)) u_chk (.*);

// File: tb/tb_syl_decoder.sv
module tb_syl_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        syl_valid_i = 1'b0;
  logic [7:0]  syl_data_i = '0;
  logic        syl_ready_o;
  logic        ins_valid_o;
  logic        ins_ready_i = 1'b0;
  logic [2:0]  ins_class_o;
  logic [7:0]  ins_op_o;
  logic [2:0]  ins_len_o;
  logic [31:0] ins_imm_o;
  logic        ins_bad_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  syl_decoder dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] b);
    if (!b[7]) return 2;
    case (b)
      8'hA0, 8'hA1, 8'hA2: return 3;
      8'hB2: return 2;
      8'hB3: return 3;
      8'hBE: return 5;
      default: return 1;
    endcase
  endfunction

  function automatic logic [2:0] exp_cls(input logic [7:0] b);
    if (!b[7]) return b[6] ? 3'd1 : 3'd0;
    case (b)
      8'hA0, 8'hA1, 8'hA2: return 3'd3;
      8'hB2, 8'hB3, 8'hBE: return 3'd4;
      8'hFF: return 3'd5;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [7:0] trail_byte(input logic [7:0] b, input int k);
    return b ^ 8'(8'h3C + 17 * k);
  endfunction

  function automatic logic [31:0] exp_imm(input logic [7:0] b);
    logic [31:0] v = '0;
    if (!b[7]) return {18'd0, b[5:0], trail_byte(b, 1)};
    for (int k = 1; k < exp_len(b); k++) v = (v << 8) | 32'(trail_byte(b, k));
    return v;
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk_i);
    syl_valid_i = 1'b1;
    syl_data_i  = b;
    while (!syl_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 syl_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic take(input logic [7:0] b, input string tag);
    @(negedge clk_i);
    while (!ins_valid_o) @(negedge clk_i);
    chk(ins_op_o == b, {tag, " op"}, 32'(ins_op_o), 32'(b));
    chk(ins_class_o == exp_cls(b), {tag, " class"}, 32'(ins_class_o), 32'(exp_cls(b)));
    chk(32'(ins_len_o) == exp_len(b), {tag, " len"}, 32'(ins_len_o), 32'(exp_len(b)));
    chk(ins_imm_o == exp_imm(b), {tag, " imm"}, ins_imm_o, exp_imm(b));
    chk(ins_bad_o == (b == 8'hFF), "R7 bad flag", 32'(ins_bad_o), 32'(b == 8'hFF));
    ins_ready_i = 1'b1;
    @(posedge clk_i);
    #1 ins_ready_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [7:0] b);
    case (exp_cls(b))
      3'd0: return "R2";
      3'd1: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ins_valid_o == 1'b0, "R1 valid after reset", 32'(ins_valid_o), 0);
    chk(syl_ready_o == 1'b1, "R1 ready after reset", 32'(syl_ready_o), 1);

    // sweep of all first syllables, gaps vary per instruction (R10)
    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      for (int k = 1; k < exp_len(8'(b)); k++) begin
        idle(b % 3);
        push(trail_byte(8'(b), k));
      end
      take(8'(b), tag_of(8'(b)));
    end

    // R8: stalled output with a syllable already offered
    push(8'hB2);
    push(trail_byte(8'hB2, 1));
    @(negedge clk_i);
    syl_valid_i = 1'b1;
    syl_data_i  = 8'h85;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(syl_ready_o == 1'b0, "R8 ready low during stall", 32'(syl_ready_o), 0);
      chk(ins_valid_o && ins_op_o == 8'hB2 && ins_imm_o == exp_imm(8'hB2),
          "R8 record held", ins_imm_o, exp_imm(8'hB2));
    end
    ins_ready_i = 1'b1;
    @(posedge clk_i);
    #1 ins_ready_i = 1'b0;
    @(posedge clk_i);
    #1 syl_valid_i = 1'b0;
    take(8'h85, "R8 offered syllable kept");

    // R9: reset in the middle of a branch
    push(8'hA2);
    push(trail_byte(8'hA2, 1));
    @(negedge clk_i);
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    chk(ins_valid_o == 1'b0, "R9 no record after reset", 32'(ins_valid_o), 0);
    push(8'h90);
    take(8'h90, "R9 restart");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule